// File: doc/BRIEF.md
# Ping-Pong Transposing Even/Odd Tile Buffer

This buffer sits between the horizontal and the vertical pass of a two-dimensional lifting wavelet transform. The horizontal pass streams a square tile into it in row-major order. Each row carries its low-pass half first and its high-pass half second, and the buffer stores that layout as it arrives. The vertical pass then drains the same tile in column-major order. On every read it receives two vertically adjacent samples of one column at once: the sample on an even row and the sample on the odd row just below it. The lifting datapath gets its even and odd streams directly, with no separate split step.

There are two banks. One bank fills while the other drains, so a tile can be written and the previous tile read in the same cycles. Each bank is made of two simple dual-port RAMs, one for even rows and one for odd rows. This lets a single read cycle deliver a full even/odd pair. The sequencer decides when the roles of the banks change by pulsing a swap request. The buffer acts on that request only after both the fill side and the drain side have finished with their current tiles.

The tile edge is a parameter. The default is kept small so the design elaborates quickly, and a 256-wide tile of 16-bit words is reached by overriding `TILE_DIM`.

Top module: `tpose_pingpong`

## Requirements
- R1: After reset, bank 0 is the fill bank, `wr_done` is 0, `rd_done` is 1 (the drain bank holds nothing to read) and `rd_valid` is 0.
- R2: Words accepted while `wr_en` is high and `wr_done` is low are stored in row-major order: accepted word i lands at row i / TILE_DIM and column i % TILE_DIM of the fill bank. `wr_done` rises in the cycle after the TILE_DIM*TILE_DIM-th word is accepted.
- R3: While `wr_done` is high, `wr_en` has no effect: the stored tile is unchanged and `wr_done` stays high until a swap is taken.
- R4: The drain bank is read column by column, from column 0 upward. Within a column, pair k is delivered in order of k, with `rd_even` holding row 2k and `rd_odd` holding row 2k+1 of that column.
- R5: A read is taken when `rd_req` is high and `rd_done` is low. Its pair appears with `rd_valid` high exactly one cycle later. `rd_valid` is low in every other cycle, including cycles where `rd_req` is high while `rd_done` is high.
- R6: `rd_col_end` is high together with `rd_valid` on the last pair of each column (k = TILE_DIM/2-1), and is low otherwise.
- R7: `rd_done` rises in the cycle after the TILE_DIM*TILE_DIM/2-th read is taken, and stays high until a swap is taken.
- R8: A `swap` pulse is taken only if `wr_done` and `rd_done` are both high in that cycle. In the next cycle `wr_bank` has toggled and both `wr_done` and `rd_done` are low. A swap that is not taken changes nothing.
- R9: Filling one bank and draining the other can proceed in the same cycle. The data drained after a swap is the tile that was filled before that swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Offer one row-pass word |
| wr_data | input | DATA_W | Row-pass word, row-major order |
| wr_done | output | 1 | Fill bank holds a complete tile |
| wr_bank | output | 1 | Index of the bank being filled |
| rd_req | input | 1 | Request one even/odd pair |
| rd_valid | output | 1 | Pair on rd_even/rd_odd is valid |
| rd_even | output | DATA_W | Sample from row 2k of the current column |
| rd_odd | output | DATA_W | Sample from row 2k+1 of the current column |
| rd_col_end | output | 1 | Pair is the last of its column |
| rd_done | output | 1 | Whole drain bank has been read |
| swap | input | 1 | Request to exchange bank roles |

## Verification
The hardest situation to reach is a swap request that arrives when only one side has finished. This is the only case where the gating on both completion flags matters. In the third tile, the stimulus throttles reads to one cycle in three while writes run at full rate. The fill side therefore completes many cycles before the drain side. A swap is pulsed in that window, and the bench confirms that the bank index, the fill data and the drain order are all unaffected. Junk writes offered after each tile completes are caught when that tile is drained in the following phase, because every word carries its tile, row and column in its value.

// File: rtl/tpose_pkg.sv
package tpose_pkg;

    // Top-level control state (bank roles and output qualifiers)
    typedef struct packed {
        logic wr_bank;     // bank currently filled
        logic rd_sel;      // bank whose RAM output is on the read port
        logic rd_valid;    // registered read strobe
        logic rd_col_end;  // registered last-of-column marker
    } top_state_t;

endpackage

// File: rtl/tpose_ram.sv
module tpose_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/tpose_wr_cnt.sv
module tpose_wr_cnt #(
    parameter int N  = 16,
    localparam int CW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic          acc,
    output logic [CW-1:0] row,
    output logic [CW-1:0] col,
    output logic          done
);

    typedef struct packed {
        logic [CW-1:0] row;
        logic [CW-1:0] col;
        logic          done;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        acc  = en && !st_q.done;
        if (clr) begin
            st_d = '0;
        end else if (acc) begin
            if (st_q.col == CW'(N - 1)) begin
                st_d.col = '0;
                st_d.row = st_q.row + 1'b1;
                if (st_q.row == CW'(N - 1)) st_d.done = 1'b1;
            end else begin
                st_d.col = st_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row  = st_q.row;
    assign col  = st_q.col;
    assign done = st_q.done;

endmodule

// File: rtl/tpose_rd_cnt.sv
module tpose_rd_cnt #(
    parameter int N  = 16,
    localparam int CW = $clog2(N),
    localparam int PW = CW - 1,
    localparam int NH = N / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          req,
    output logic          fire,
    output logic          col_end,
    output logic [CW-1:0] col,
    output logic [PW-1:0] pair,
    output logic          done
);

    typedef struct packed {
        logic [CW-1:0] col;
        logic [PW-1:0] pair;
        logic          done;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        fire    = req && !st_q.done;
        col_end = (st_q.pair == PW'(NH - 1));
        if (clr) begin
            st_d = '0;
        end else if (fire) begin
            if (col_end) begin
                st_d.pair = '0;
                st_d.col  = st_q.col + 1'b1;
                if (st_q.col == CW'(N - 1)) st_d.done = 1'b1;
            end else begin
                st_d.pair = st_q.pair + 1'b1;
            end
        end
    end

    // The drain side starts empty: nothing to read until the first swap
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{col: '0, pair: '0, done: 1'b1};
        else        st_q <= st_d;
    end

    assign col  = st_q.col;
    assign pair = st_q.pair;
    assign done = st_q.done;

endmodule

// File: rtl/tpose_pingpong.sv
module tpose_pingpong
    import tpose_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int TILE_DIM = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_done,
    output logic              wr_bank,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_even,
    output logic [DATA_W-1:0] rd_odd,
    output logic              rd_col_end,
    output logic              rd_done,
    input  logic              swap
);

    localparam int CW    = $clog2(TILE_DIM);
    localparam int PW    = CW - 1;
    localparam int AW    = PW + CW;
    localparam int DEPTH = TILE_DIM * TILE_DIM / 2;

    top_state_t st_d, st_q;

    logic          wr_acc, rd_fire, rd_last_c, swap_ok, rd_bank;
    logic [CW-1:0] wr_row, wr_col, rd_col;
    logic [PW-1:0] rd_pair;
    logic [AW-1:0] waddr, raddr;
    logic [DATA_W-1:0] rdat [4];

    assign swap_ok = swap && wr_done && rd_done;
    assign rd_bank = ~st_q.wr_bank;

    tpose_wr_cnt #(.N(TILE_DIM)) wr_cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(swap_ok), .en(wr_en),
        .acc(wr_acc), .row(wr_row), .col(wr_col), .done(wr_done)
    );

    tpose_rd_cnt #(.N(TILE_DIM)) rd_cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(swap_ok), .req(rd_req),
        .fire(rd_fire), .col_end(rd_last_c), .col(rd_col), .pair(rd_pair),
        .done(rd_done)
    );

    // Row parity picks the sub-RAM; the pair index and column form the address
    assign waddr = {wr_row[CW-1:1], wr_col};
    assign raddr = {rd_pair, rd_col};

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar p = 0; p < 2; p++) begin : g_par
            tpose_ram #(.DW(DATA_W), .DEPTH(DEPTH)) ram_i (
                .clk  (clk),
                .we   (wr_acc && (st_q.wr_bank == 1'(b)) && (wr_row[0] == 1'(p))),
                .waddr(waddr),
                .wdata(wr_data),
                .re   (rd_fire && (rd_bank == 1'(b))),
                .raddr(raddr),
                .rdata(rdat[b * 2 + p])
            );
        end
    end

    always_comb begin
        st_d            = st_q;
        st_d.rd_valid   = rd_fire;
        st_d.rd_col_end = rd_fire && rd_last_c;
        if (rd_fire) st_d.rd_sel = rd_bank;
        if (swap_ok) st_d.wr_bank = ~st_q.wr_bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{wr_bank: 1'b0, rd_sel: 1'b1, rd_valid: 1'b0, rd_col_end: 1'b0};
        else        st_q <= st_d;
    end

    assign wr_bank    = st_q.wr_bank;
    assign rd_valid   = st_q.rd_valid;
    assign rd_col_end = st_q.rd_col_end;
    assign rd_even    = st_q.rd_sel ? rdat[2] : rdat[0];
    assign rd_odd     = st_q.rd_sel ? rdat[3] : rdat[1];

endmodule

// File: rtl/tpose_chk.sv
module tpose_chk (
    input logic clk,
    input logic rst_n,
    input logic swap,
    input logic wr_done,
    input logic wr_bank,
    input logic rd_req,
    input logic rd_done,
    input logic rd_valid,
    input logic rd_col_end
);

    // R5: a taken read is answered one cycle later
    p_valid_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_done) |=> rd_valid);

    // R5: no strobe without a taken read
    p_no_spurious_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && !rd_done) |=> !rd_valid);

    // R6: column end only marks a valid pair
    p_col_end_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_col_end |-> rd_valid);

    // R8: refused swap leaves bank roles alone
    p_swap_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !(wr_done && rd_done)) |=> $stable(wr_bank));

    // R8: accepted swap toggles bank and clears both sides
    p_swap_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && wr_done && rd_done) |=> (wr_bank != $past(wr_bank)) && !wr_done && !rd_done);

    // R3: a full fill bank stays full until a swap is taken
    p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !(swap && rd_done)) |=> wr_done);

    // R7: a drained bank stays drained until a swap is taken
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !(swap && wr_done)) |=> rd_done);

endmodule

bind tpose_pingpong tpose_chk chk_i (
    .clk(clk), .rst_n(rst_n), .swap(swap), .wr_done(wr_done), .wr_bank(wr_bank),
    .rd_req(rd_req), .rd_done(rd_done), .rd_valid(rd_valid), .rd_col_end(rd_col_end)
);

// File: tb/tpose_pingpong_tb_top.sv
module tpose_pingpong_tb_top;

    localparam int DW = 16;
    localparam int N  = 8;
    localparam int NN = N * N;
    localparam int NH = N / 2;
    localparam int NP = NN / 2;

    logic clk = 1'b0;
    logic rst_n;
    logic wr_en, rd_req, swap;
    logic [DW-1:0] wr_data;
    logic wr_done, wr_bank, rd_valid, rd_col_end, rd_done;
    logic [DW-1:0] rd_even, rd_odd;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit exp_bank = 0;

    always #5 clk = ~clk;

    tpose_pingpong #(.DATA_W(DW), .TILE_DIM(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_done(wr_done), .wr_bank(wr_bank), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_even(rd_even), .rd_odd(rd_odd),
        .rd_col_end(rd_col_end), .rd_done(rd_done), .swap(swap)
    );

    // Word value encodes tile, row and column
    function automatic logic [DW-1:0] val(int t, int r, int c);
        return DW'(t * 4096 + r * 64 + c);
    endfunction

    task automatic chk(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    // One tile period: fill tile t (if t < 4) while draining tile t-1 (if t > 0)
    task automatic run_phase(int t);
        int wlim = (t < 4) ? NN : 0;
        int wi = 0;
        int ri = (t == 0) ? NP : 0;
        int pc = 0;
        int extra = 0;
        int cyc = 0;
        bit pend = 0;
        bit tried = 0;
        bit fire_m, acc_m;
        while (1) begin
            if (pend) begin
                int k = pc % NH;
                int c = pc / NH;
                chk("R5", rd_valid == 1'b1, rd_valid, 1);
                chk("R4 R9 even", rd_even == val(t - 1, 2 * k, c), rd_even, val(t - 1, 2 * k, c));
                chk("R4 R3 odd", rd_odd == val(t - 1, 2 * k + 1, c), rd_odd, val(t - 1, 2 * k + 1, c));
                chk("R6", rd_col_end == (k == NH - 1), rd_col_end, int'(k == NH - 1));
            end else begin
                chk("R5 idle", rd_valid == 1'b0, rd_valid, 0);
            end
            chk("R7", rd_done == (ri == NP), rd_done, int'(ri == NP));
            chk("R2", wr_done == (t < 4 && wi == NN), wr_done, int'(t < 4 && wi == NN));
            chk("R8 bank", wr_bank == exp_bank, wr_bank, exp_bank);
            if (extra == 3) break;
            if (wi == wlim && ri == NP) extra++;
            wr_en  = (t < 4) && (t != 1 || cyc % 2 == 0);
            // R3: words offered after the tile is complete are junk and must be dropped
            wr_data = (wi < wlim) ? val(t, wi / N, wi % N) : 16'hDEAD;
            rd_req = (t == 2) ? (cyc % 3 == 0) : 1'b1;
            // R8: swap while only the fill side is finished must be refused
            swap = 1'b0;
            if (t == 2 && wi == NN && ri < NP && !tried) begin
                swap  = 1'b1;
                tried = 1;
            end
            fire_m = rd_req && ri < NP;
            acc_m  = wr_en && wi < wlim;
            pend = fire_m;
            pc   = ri;
            @(negedge clk);
            ri += int'(fire_m);
            wi += int'(acc_m);
            cyc++;
        end
        if (t == 2) chk("R8 refused swap tried", tried, tried, 1);
        wr_en  = 1'b0;
        rd_req = 1'b0;
        swap   = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_req = 1'b0; swap = 1'b0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bank", wr_bank == 1'b0, wr_bank, 0);
        chk("R1 wr_done", wr_done == 1'b0, wr_done, 0);
        chk("R1 rd_done", rd_done == 1'b1, rd_done, 1);
        chk("R1 rd_valid", rd_valid == 1'b0, rd_valid, 0);
        // R8: swap with an empty fill bank is refused
        swap = 1'b1;
        @(negedge clk);
        swap = 1'b0;
        chk("R8 early swap", wr_bank == 1'b0, wr_bank, 0);
        for (int t = 0; t < 5; t++) begin
            run_phase(t);
            if (t < 4) begin
                swap = 1'b1;
                @(negedge clk);
                swap = 1'b0;
                exp_bank = ~exp_bank;
                chk("R8 toggle", wr_bank == exp_bank, wr_bank, exp_bank);
                chk("R8 wr clear", wr_done == 1'b0, wr_done, 0);
                chk("R8 rd clear", rd_done == 1'b0, rd_done, 0);
            end
        end
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule